// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block divides a 32768 Hz time-base strobe down to a programmable periodic event for a real-time-clock subsystem. A 4-bit rate code in control register A picks the period. Codes 3 to 15 follow a power-of-two ladder from 8192 Hz down to 2 Hz. Codes 1 and 2 break that ladder and give 256 Hz and 128 Hz. Code 0 turns the generator off. A 3-bit divider field in the same register gates the prescaler: only the run pattern `010` lets it count.

Each completed period sets a sticky periodic flag. The flag drives an interrupt request when the enable bit in control register B is set. A square-wave output at the selected rate can also be enabled. Software reaches both control registers and a status register through a small address/data port. Reading the status register clears the flag. The remaining bits of register B are storage only, for neighbouring logic that decodes them.

Top module: `rtc_pir`

## Requirements
- R1: After reset, control A reads 0x20, control B reads 0x00, the status register reads 0x00, and `irq_o` and `sqw_o` are low.
- R2: All eight bits of control B (address 1) read back as written. Bits 6:0 of control A (address 0) read back as written. Bit 7 of control A (update-in-progress) always reads 0, and writes to it are ignored.
- R3: With rate code 0 (control A bits 3:0), the periodic flag is never set and `sqw_o` stays low.
- R4: With divider field `010` (control A bits 6:4) and a rate code n from 3 to 15, the flag is set 2^(n-1) time-base ticks after the write that selected the code.
- R5: Rate code 1 gives a period of 128 ticks (256 Hz). Rate code 2 gives a period of 256 ticks (128 Hz).
- R6: The flag is set whether or not the interrupt is enabled. `irq_o` is high exactly when the flag is set and control B bit 6 is 1.
- R7: A read of the status register (address 2) returns the irq state in bit 7 and the flag in bit 6. The flag is cleared after the read.
- R8: If a period ends in the same cycle as a status read, the read returns the old flag and the flag stays set.
- R9: With control B bit 3 set and a nonzero code, `sqw_o` is low for the first half period after the selecting write, high for the second half, and then keeps toggling every half period. With control B bit 3 clear, `sqw_o` is low.
- R10: With any divider field other than `010`, the prescaler is held cleared and produces no period. Restoring `010` starts a fresh full period.
- R11: Any write to control A restarts the period count from zero, even part-way through a long period.
- R12: The prescaler advances only in cycles where `tick_i` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe at the 32768 Hz time base |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (status reads clear the flag) |
| addr_i | input | 2 | Register address: 0 control A, 1 control B, 2 status |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the addressed register |
| irq_o | output | 1 | Periodic interrupt request |
| sqw_o | output | 1 | Square-wave output at the selected rate |

## Verification
The hardest case to produce is a status read that falls in the exact cycle a period ends (R8). The bench makes this deterministic. It writes control A with the fastest code while ticks run every cycle, which zeroes the prescaler on a known edge. It then counts clock edges to the final tick of the first period and places the read there. A later write of code 0 freezes the flag so the outcome can be read back. Period lengths for every code class are measured from the selecting write to the rise of `irq_o`. The measurements include the two remapped codes and a rewrite of code 15 part-way through its period.

// File: rtl/rtc_pir_pkg.sv
package rtc_pir_pkg;
  localparam int REG_W   = 8;
  localparam int ADDR_W  = 2;
  localparam int RS_W    = 4;
  localparam int DV_W    = 3;
  // longest half period: code (2^RS_W - 1) -> 2^(2^RS_W - 3) ticks
  localparam int HALF_MAX = 1 << ((1 << RS_W) - 3);
  localparam int CNT_W   = $clog2(HALF_MAX);

  localparam logic [ADDR_W-1:0] ADDR_CTLA = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTLB = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

  localparam logic [DV_W-1:0]  DV_RUN   = 3'b010;
  localparam logic [REG_W-1:0] CTLA_RST = 8'h20;
  localparam logic [REG_W-1:0] CTLB_RST = 8'h00;

  localparam int B_PIE  = 6;
  localparam int B_SQWE = 3;
  localparam int S_IRQ  = 7;
  localparam int S_FLAG = 6;

  // last counter value of a half period for a rate code
  function automatic logic [CNT_W-1:0] half_last(input logic [RS_W-1:0] rs);
    logic [CNT_W-1:0] r;
    if (rs == '0)
      r = '0;
    else if (rs == RS_W'(1))
      r = CNT_W'(63);
    else if (rs == RS_W'(2))
      r = CNT_W'(127);
    else
      r = CNT_W'((32'd1 << (rs - RS_W'(2))) - 32'd1);
    return r;
  endfunction
endpackage

// File: rtl/rtc_pir_regs.sv
module rtc_pir_regs
  import rtc_pir_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  ctl_a,
  output logic [REG_W-1:0]  ctl_b,
  output logic              a_wr
);
  logic [REG_W-2:0] a_q, a_d;
  logic [REG_W-1:0] b_q, b_d;
  logic             b_wr;

  always_comb begin
    a_wr = wr_en && (addr == ADDR_CTLA);
    b_wr = wr_en && (addr == ADDR_CTLB);
    a_d  = a_q;
    b_d  = b_q;
    if (a_wr) a_d = wdata[REG_W-2:0];
    if (b_wr) b_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= CTLA_RST[REG_W-2:0];
      b_q <= CTLB_RST;
    end else begin
      if (a_wr) a_q <= a_d;
      if (b_wr) b_q <= b_d;
    end
  end

  // top bit of A is the read-only update-in-progress flag; no update logic here
  assign ctl_a = {1'b0, a_q};
  assign ctl_b = b_q;
endmodule

// File: rtl/rtc_pir_rate_dec.sv
module rtc_pir_rate_dec
  import rtc_pir_pkg::*;
(
  input  logic [REG_W-1:0] ctl_a,
  output logic [CNT_W-1:0] last,
  output logic             run
);
  logic [RS_W-1:0] rs;
  logic [DV_W-1:0] dv;

  always_comb begin
    rs   = ctl_a[RS_W-1:0];
    dv   = ctl_a[RS_W+DV_W-1:RS_W];
    last = half_last(rs);
    run  = (rs != '0) && (dv == DV_RUN);
  end
endmodule

// File: rtl/rtc_pir_prescaler.sv
module rtc_pir_prescaler
  import rtc_pir_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             reload,
  input  logic [CNT_W-1:0] last,
  output logic             half_pulse,
  output logic             period_pulse,
  output logic             phase
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ph_d;
  logic             cnt_en;

  always_comb begin
    half_pulse   = run && tick && (cnt_q == last);
    period_pulse = half_pulse && phase;
    cnt_en       = reload || !run || tick;
    cnt_d        = cnt_q;
    ph_d         = phase;
    if (reload || !run) begin
      cnt_d = '0;
      ph_d  = 1'b0;
    end else if (tick) begin
      if (half_pulse) begin
        cnt_d = '0;
        ph_d  = !phase;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      phase <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      phase <= ph_d;
    end
  end
endmodule

// File: rtl/rtc_pir.sv
module rtc_pir
  import rtc_pir_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_o,
  output logic              sqw_o
);
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;
  logic [REG_W-1:0]       ctl_a, ctl_b;
  logic                   a_wr;
  logic [CNT_W-1:0]       last;
  logic                   run;
  logic                   half_pulse, period_pulse, phase;
  logic                   flag_q, flag_d, stat_rd;

  // reset asserts at once, releases after SYNC_STAGES edges
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe <= '0;
        else        rst_pipe <= 1'b1;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe <= '0;
        else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
      end
    end
  endgenerate
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  rtc_pir_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en_i), .addr(addr_i),
    .wdata(wdata_i), .ctl_a(ctl_a), .ctl_b(ctl_b), .a_wr(a_wr)
  );

  rtc_pir_rate_dec u_dec (.ctl_a(ctl_a), .last(last), .run(run));

  rtc_pir_prescaler u_pre (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick_i), .run(run), .reload(a_wr),
    .last(last), .half_pulse(half_pulse), .period_pulse(period_pulse),
    .phase(phase)
  );

  always_comb begin
    stat_rd = rd_en_i && (addr_i == ADDR_STAT);
    flag_d  = flag_q;
    if (period_pulse) flag_d = 1'b1;
    else if (stat_rd) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) flag_q <= 1'b0;
    else             flag_q <= flag_d;
  end

  assign irq_o = flag_q && ctl_b[B_PIE];
  assign sqw_o = phase && ctl_b[B_SQWE];

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTLA: rdata_o = ctl_a;
      ADDR_CTLB: rdata_o = ctl_b;
      ADDR_STAT: begin
        rdata_o[S_IRQ]  = irq_o;
        rdata_o[S_FLAG] = flag_q;
      end
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rtc_pir_chk.sv
module rtc_pir_chk
  import rtc_pir_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [REG_W-1:0]  wdata_i,
  input logic [REG_W-1:0]  ctl_a,
  input logic [REG_W-1:0]  ctl_b,
  input logic              half_pulse,
  input logic              period_pulse,
  input logic              flag_q,
  input logic              irq_o,
  input logic              sqw_o
);
  // R2
  ctlb_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == ADDR_CTLB) |=> (ctl_b == $past(wdata_i)));
  // R2
  uip_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_a[REG_W-1] == 1'b0);
  // R3
  off_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_a[RS_W-1:0] == '0) |-> !half_pulse);
  // R10
  dv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_a[RS_W+DV_W-1:RS_W] != DV_RUN) |-> !half_pulse);
  // R12
  tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half_pulse |-> tick_i);
  // R6
  irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ctl_b[B_PIE]);
  // R7
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == ADDR_STAT && !period_pulse) |=> !flag_q);
  // R8
  pulse_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_pulse |=> flag_q);
  // R9
  sqw_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_b[B_SQWE] |-> !sqw_o);
endmodule

bind rtc_pir rtc_pir_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
  .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i), .ctl_a(ctl_a),
  .ctl_b(ctl_b), .half_pulse(half_pulse), .period_pulse(period_pulse),
  .flag_q(flag_q), .irq_o(irq_o), .sqw_o(sqw_o)
);

// File: tb/rtc_pir_test.sv
module rtc_pir_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o, sqw_o;
  int         errors = 0;
  int         checks = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  rtc_pir uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o), .sqw_o(sqw_o)
  );

  // rate code table and expected period in ticks (R4, R5)
  localparam int NV = 10;
  localparam int VRS [NV]  = '{1, 2, 3, 4, 5, 6, 7, 9, 12, 15};
  localparam int VPER [NV] = '{128, 256, 4, 8, 16, 32, 64, 256, 2048, 16384};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk); wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en_i = 1'b1; addr_i = a; #1 d = rdata_o;
    @(negedge clk); rd_en_i = 1'b0;
  endtask

  // select code, then count edges until irq rises (control B bit 6 must be set)
  task automatic measure(input logic [7:0] a_val, output int k);
    logic [7:0] d;
    wr(2'd0, 8'h20);
    rd(2'd2, d);
    wr(2'd0, a_val);
    k = 0;
    while (!irq_o && k < 40000) begin
      @(negedge clk); k++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int k;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(2'd0, d); check("R1 ctlA", d, 8'h20);
    rd(2'd1, d); check("R1 ctlB", d, 8'h00);
    rd(2'd2, d); check("R1 status", d, 8'h00);
    check("R1 irq", irq_o, 0);
    check("R1 sqw", sqw_o, 0);

    // R2 readback
    wr(2'd1, 8'hA5); rd(2'd1, d); check("R2 ctlB A5", d, 8'hA5);
    wr(2'd1, 8'h5A); rd(2'd1, d); check("R2 ctlB 5A", d, 8'h5A);
    wr(2'd0, 8'hF0); rd(2'd0, d); check("R2 ctlA uip", d, 8'h70);
    wr(2'd0, 8'h20);

    // R4/R5 table walk, ticks every cycle, irq enabled
    tick_i = 1'b1;
    wr(2'd1, 8'h40);
    for (int i = 0; i < NV; i++) begin
      measure(8'h20 | 8'(VRS[i]), k);
      check((VRS[i] < 3) ? "R5 period" : "R4 period", k, VPER[i]);
    end

    // R3 code 0: no flag, sqw low
    wr(2'd1, 8'h48);
    wr(2'd0, 8'h20); rd(2'd2, d);
    repeat (300) @(negedge clk);
    rd(2'd2, d); check("R3 flag", d, 8'h00);
    check("R3 sqw", sqw_o, 0);

    // R9 square wave, code 3: half period 2
    wr(2'd0, 8'h23);
    check("R9 sqw low k0", sqw_o, 0);
    @(negedge clk); check("R9 sqw low k1", sqw_o, 0);
    @(negedge clk); check("R9 sqw high k2", sqw_o, 1);
    @(negedge clk); check("R9 sqw high k3", sqw_o, 1);
    @(negedge clk); check("R9 sqw low k4", sqw_o, 0);
    @(negedge clk); @(negedge clk); check("R9 sqw high k6", sqw_o, 1);
    wr(2'd1, 8'h40);
    repeat (5) @(negedge clk); check("R9 sqw disabled", sqw_o, 0);

    // R6/R7 flag without enable, read clears
    wr(2'd1, 8'h00);
    measure(8'h23, k);
    check("R6 irq masked", irq_o, 0);
    wr(2'd0, 8'h20);
    rd(2'd2, d); check("R7 flag read", d, 8'h40);
    rd(2'd2, d); check("R7 flag cleared", d, 8'h00);
    wr(2'd1, 8'h40);
    measure(8'h23, k);
    check("R6 irq enabled", irq_o, 1);
    wr(2'd0, 8'h20);
    rd(2'd2, d); check("R7 status irq+flag", d, 8'hC0);
    check("R6 irq after clear", irq_o, 0);

    // R8 read in the cycle a period ends (code 3, pulse before 4th edge)
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h20); rd(2'd2, d);
    wr(2'd0, 8'h23);
    repeat (3) @(negedge clk);
    rd_en_i = 1'b1; addr_i = 2'd2; #1 d = rdata_o;
    check("R8 old flag", d, 8'h00);
    @(negedge clk); rd_en_i = 1'b0;
    wr(2'd0, 8'h20);
    rd(2'd2, d); check("R8 flag kept", d, 8'h40);

    // R10 divider held
    wr(2'd1, 8'h48);
    wr(2'd0, 8'h20); rd(2'd2, d);
    wr(2'd0, 8'h03);
    repeat (50) @(negedge clk);
    check("R10 no irq", irq_o, 0);
    check("R10 no sqw", sqw_o, 0);
    wr(2'd0, 8'h63);
    repeat (20) @(negedge clk);
    check("R10 dv 110 no irq", irq_o, 0);
    measure(8'h23, k); check("R10 resume period", k, 4);

    // R11 restart mid-period
    wr(2'd0, 8'h20); rd(2'd2, d);
    wr(2'd0, 8'h2F);
    repeat (1000) @(negedge clk);
    wr(2'd0, 8'h23);
    k = 0;
    while (!irq_o && k < 40000) begin @(negedge clk); k++; end
    check("R11 restart period", k, 4);

    // R12 no ticks, no progress
    wr(2'd0, 8'h20); rd(2'd2, d);
    tick_i = 1'b0;
    wr(2'd0, 8'h23);
    repeat (50) @(negedge clk);
    check("R12 no tick irq", irq_o, 0);
    check("R12 no tick sqw", sqw_o, 0);
    tick_i = 1'b1;
    k = 0;
    while (!irq_o && k < 40000) begin @(negedge clk); k++; end
    check("R12 tick resumes", k, 4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule